// File: doc/BRIEF.md
# Circular Event Queue Writer

This block turns a stream of interrupt events into 32-bit words appended to a ring buffer in memory. Each accepted event carries a 31-bit event data value. The block forms one entry from that value and a generation bit placed in bit 31, and issues one write to the memory port at the ring's base address plus four times the current slot index. It then moves the index on by one slot.

When the index passes the last slot it wraps to zero and the generation bit inverts. A consumer that remembers which generation it expects can therefore tell fresh entries from stale ones without sharing a tail pointer. The ring size is set as the log2 of its slot count, so only power-of-two sizes exist. The ring's base address is set by the same configuration write.

The current slot index, the slot count, the generation bit and the last word written are all visible on output ports. The memory side is a simple write request that stays up until the memory acknowledges it. Only one write is ever in flight.

Top module: `evq_writer`

## Requirements
- R1: After synchronous active-low reset, `cur_index` is 0, `toggle` is 1, `last_entry` is 0, `mem_req_valid` is 0, `evt_ready` is 1, the base address is 0 and `max_count` is 2^RST_LOG2 (16 by default).
- R2: An event is accepted on a rising edge where `evt_valid` and `evt_ready` are both 1. Right after that edge, `mem_req_valid` is 1 and `mem_req_wdata` holds the generation bit in bit 31 and `evt_data` in bits 30:0. The generation bit used is the `toggle` value from before the acceptance.
- R3: `mem_req_addr` equals the base address plus 4 times the pre-acceptance slot index, taken modulo 2^ADDR_W.
- R4: Each accepted event advances `cur_index` by one. The new value is visible right after the accepting edge, and `cur_index` is always below `max_count`.
- R5: An event accepted while `cur_index` equals `max_count`-1 sets `cur_index` to 0 and inverts `toggle`. No other event changes `toggle`.
- R6: From the accepting edge until the edge where `mem_req_ack` is sampled high, `mem_req_valid` stays 1, the address and data stay constant, and `evt_ready` is 0. After the acknowledging edge, `mem_req_valid` is 0 and `evt_ready` returns to 1.
- R7: On the edge where an outstanding write is acknowledged, `last_entry` takes the written word.
- R8: A configuration write (`cfg_we` high at an edge) whose size or base differs from the held values loads them and sets `cur_index` to 0 and `toggle` to 1. While `cfg_we` is high, `evt_ready` is 0 and no event is accepted.
- R9: A configuration write whose clamped size and base both equal the held values leaves `cur_index` and `toggle` unchanged.
- R10: `max_count` equals 2^L, where L is the written `cfg_log2` clamped to at most MAX_LOG2 (14 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_log2 | input | LOG2_IN_W | Log2 of slot count (clamped to MAX_LOG2) |
| cfg_base | input | ADDR_W | Ring base byte address |
| evt_valid | input | 1 | Event request |
| evt_ready | output | 1 | Event can be accepted this cycle |
| evt_data | input | 31 | Event data value |
| mem_req_valid | output | 1 | Memory write outstanding |
| mem_req_addr | output | ADDR_W | Write byte address |
| mem_req_wdata | output | 32 | Write data (generation bit in bit 31) |
| mem_req_ack | input | 1 | Memory accepted the write |
| cur_index | output | MAX_LOG2 | Next slot to be written |
| max_count | output | MAX_LOG2+1 | Slot count of the ring |
| toggle | output | 1 | Current generation bit |
| last_entry | output | 32 | Last word acknowledged by memory |

## Verification
The bench goes after the wrap slot. A design that wraps one slot early or late, or forgets to flip the generation bit, writes entries the consumer misreads. The bench also covers the one-slot ring, where the bit flips on every write, and a base address near the top of the address space, where a wrong address width would corrupt the carry. Configuration writes are checked both with changed values, which must restart the ring, and with identical values, which must not. An event presented in the same cycle as a configuration write must be refused; a design that takes it would write into a ring that is being redefined. Acknowledge delays of zero to several cycles check that the request holds still and that a second event is refused while a write is in flight.

// File: rtl/evq_pkg.sv
// Shared types for the circular event queue writer.
// Assumes the entry word is 32 bits with the generation bit on top.
package evq_pkg;
    localparam int ENTRY_W = 32;
    localparam int DATA_W  = ENTRY_W - 1;

    typedef struct packed {
        logic              gen;
        logic [DATA_W-1:0] data;
    } evq_entry_t;
endpackage

// File: rtl/evq_cfg.sv
// Holds the ring size (log2, clamped) and the base address.
// Raises 'restart' in the cycle of a configuration write that changes either.
// Assumes MAX_LOG2 fits in LOG2_IN_W bits.
module evq_cfg #(
    parameter int ADDR_W    = 32,
    parameter int MAX_LOG2  = 14,
    parameter int LOG2_IN_W = 5,
    parameter int RST_LOG2  = 4,
    localparam int LOG2_W   = $clog2(MAX_LOG2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [LOG2_IN_W-1:0] cfg_log2,
    input  logic [ADDR_W-1:0] cfg_base,
    output logic [LOG2_W-1:0] log2_q,
    output logic [ADDR_W-1:0] base_q,
    output logic              restart
);
    logic [LOG2_IN_W-1:0] clamped_in;
    logic [LOG2_W-1:0]    clamped;

    // Limit the requested size to the largest ring the index can address.
    always_comb begin
        clamped_in = (cfg_log2 > LOG2_IN_W'(MAX_LOG2)) ? LOG2_IN_W'(MAX_LOG2) : cfg_log2;
        clamped    = LOG2_W'(clamped_in);
        restart    = cfg_we && ((clamped != log2_q) || (cfg_base != base_q));
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log2_q <= LOG2_W'(RST_LOG2);
            base_q <= '0;
        end else if (cfg_we) begin
            log2_q <= clamped;
            base_q <= cfg_base;
        end
    end

    assert_size_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (log2_q <= LOG2_W'(MAX_LOG2)));
    assert_base_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (base_q == $past(cfg_base)));
endmodule

// File: rtl/evq_index.sv
// Slot index and generation bit of the ring.
// Advances one slot per accepted event and wraps at last_idx, inverting the bit.
// Assumes 'restart' and 'advance' are never high together.
module evq_index #(
    parameter int IDX_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] idx,
    output logic             gen
);
    // Index and generation update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            gen <= 1'b1;
        end else if (restart) begin
            idx <= '0;
            gen <= 1'b1;
        end else if (advance) begin
            if (idx == last_idx) begin
                idx <= '0;
                gen <= ~gen;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assert_wrap_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart && idx == last_idx) |=> (idx == '0 && gen != $past(gen)));
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart && idx != last_idx) |=> (idx == $past(idx) + 1'b1 && $stable(gen)));
    assert_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= last_idx);
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (idx == '0 && gen));
endmodule

// File: rtl/evq_wr_port.sv
// Single-entry write request register towards memory.
// Holds address and data until acknowledged, then records the written word.
// Assumes mem_ack is only meaningful while a request is up.
module evq_wr_port #(
    parameter int ADDR_W  = 32,
    parameter int ENTRY_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic [ENTRY_W-1:0] word_in,
    input  logic               mem_ack,
    output logic               mem_valid,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ENTRY_W-1:0] mem_wdata,
    output logic [ENTRY_W-1:0] last_word
);
    logic done;
    assign done = mem_valid && mem_ack;

    // Request register: load on accept, drop on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (load) begin
            mem_valid <= 1'b1;
            mem_addr  <= addr_in;
            mem_wdata <= word_in;
        end else if (done) begin
            mem_valid <= 1'b0;
        end
    end

    // Record of the last word the memory took.
    always_ff @(posedge clk) begin
        if (!rst_n) last_word <= '0;
        else if (done) last_word <= mem_wdata;
    end

    assert_hold_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));
    assert_last_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (last_word == $past(mem_wdata) && !mem_valid));
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !mem_valid);
endmodule

// File: rtl/evq_writer.sv
// Circular event queue writer: appends {generation, data} words to a
// power-of-two ring in memory, one outstanding write at a time.
// Assumes MAX_LOG2 + 2 <= ADDR_W so the byte offset fits the address.
module evq_writer #(
    parameter int ADDR_W    = 32,
    parameter int MAX_LOG2  = 14,
    parameter int LOG2_IN_W = 5,
    parameter int RST_LOG2  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [LOG2_IN_W-1:0] cfg_log2,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic                 evt_valid,
    output logic                 evt_ready,
    input  logic [30:0]          evt_data,
    output logic                 mem_req_valid,
    output logic [ADDR_W-1:0]    mem_req_addr,
    output logic [31:0]          mem_req_wdata,
    input  logic                 mem_req_ack,
    output logic [MAX_LOG2-1:0]  cur_index,
    output logic [MAX_LOG2:0]    max_count,
    output logic                 toggle,
    output logic [31:0]          last_entry
);
    import evq_pkg::*;

    localparam int IDX_W  = MAX_LOG2;
    localparam int LOG2_W = $clog2(MAX_LOG2 + 1);

    logic [LOG2_W-1:0] log2_q;
    logic [ADDR_W-1:0] base_q;
    logic              restart;
    logic              accept;
    logic [IDX_W-1:0]  last_idx;
    logic [ADDR_W-1:0] slot_addr;
    evq_entry_t        entry;

    evq_cfg #(
        .ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2),
        .LOG2_IN_W(LOG2_IN_W), .RST_LOG2(RST_LOG2)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_log2(cfg_log2),
        .cfg_base(cfg_base), .log2_q(log2_q), .base_q(base_q), .restart(restart)
    );

    // Handshake, slot count and the word/address of the next slot.
    always_comb begin
        evt_ready  = !mem_req_valid && !cfg_we;
        accept     = evt_valid && evt_ready;
        max_count  = (IDX_W + 1)'(1) << log2_q;
        last_idx   = IDX_W'(max_count - 1'b1);
        entry.gen  = toggle;
        entry.data = evt_data;
        slot_addr  = base_q + ADDR_W'({cur_index, 2'b00});
    end

    evq_index #(.IDX_W(IDX_W)) index_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .advance(accept),
        .last_idx(last_idx), .idx(cur_index), .gen(toggle)
    );

    evq_wr_port #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) port_i (
        .clk(clk), .rst_n(rst_n), .load(accept), .addr_in(slot_addr),
        .word_in(entry), .mem_ack(mem_req_ack), .mem_valid(mem_req_valid),
        .mem_addr(mem_req_addr), .mem_wdata(mem_req_wdata), .last_word(last_entry)
    );

    assert_gen_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (mem_req_wdata[31] == $past(toggle) && mem_req_wdata[30:0] == $past(evt_data)));
    assert_ready_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !evt_ready);
    assert_cfg_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !mem_req_valid) |=> !mem_req_valid);
endmodule

// File: tb/evq_writer_tb.sv
`timescale 1ns/1ps
module evq_writer_tb_top;
    localparam int MAX_LOG2 = 14;
    localparam int RST_LOG2 = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_log2 = '0;
    logic [31:0] cfg_base = '0;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [30:0] evt_data = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_req_ack = 1'b0;
    logic [MAX_LOG2-1:0] cur_index;
    logic [MAX_LOG2:0]   max_count;
    logic        toggle;
    logic [31:0] last_entry;

    int checks = 0;
    int errors = 0;
    int m_idx, m_log2;
    logic [31:0] m_base;
    logic m_tog;

    always #2 clk = ~clk;

    evq_writer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_log2(cfg_log2),
        .cfg_base(cfg_base), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_data(evt_data), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ack(mem_req_ack), .cur_index(cur_index), .max_count(max_count),
        .toggle(toggle), .last_entry(last_entry)
    );

    function automatic int clamp_log2(input int l);
        return (l > MAX_LOG2) ? MAX_LOG2 : l;
    endfunction

    function automatic logic [31:0] slot_addr(input logic [31:0] b, input int i);
        return b + 32'(i) * 32'd4;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk(cur_index == MAX_LOG2'(m_idx), req, 32'(cur_index), 32'(m_idx));
        chk(toggle == m_tog, req, 32'(toggle), 32'(m_tog));
        chk(max_count == (MAX_LOG2+1)'(1 << m_log2), req, 32'(max_count), 32'(1 << m_log2));
    endtask

    // One event, acknowledged after dly idle cycles.
    task automatic push(input logic [30:0] d, input int dly);
        logic [31:0] w, a;
        @(negedge clk);
        while (!evt_ready) @(negedge clk);
        evt_valid = 1'b1;
        evt_data  = d;
        w = {m_tog, d};
        a = slot_addr(m_base, m_idx);
        @(posedge clk); #1;
        chk(mem_req_valid == 1'b1, "R2 valid", 32'(mem_req_valid), 32'd1);
        chk(mem_req_wdata == w, "R2 wdata", mem_req_wdata, w);
        chk(mem_req_addr == a, "R3 addr", mem_req_addr, a);
        chk(evt_ready == 1'b0, "R6 busy", 32'(evt_ready), 32'd0);
        if (m_idx == (1 << m_log2) - 1) begin
            m_idx = 0;
            m_tog = ~m_tog;
        end else begin
            m_idx++;
        end
        check_state("R4/R5 index");
        @(negedge clk);
        evt_valid = 1'b0;
        repeat (dly) @(negedge clk);
        chk(mem_req_valid && mem_req_addr == a && mem_req_wdata == w && !evt_ready,
            "R6 hold", mem_req_wdata, w);
        mem_req_ack = 1'b1;
        @(posedge clk); #1;
        chk(last_entry == w, "R7 last", last_entry, w);
        chk(!mem_req_valid && evt_ready, "R6 release", 32'(mem_req_valid), 32'd0);
        @(negedge clk);
        mem_req_ack = 1'b0;
    endtask

    task automatic cfg(input int l, input logic [31:0] b);
        bit change;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_log2 = 5'(l);
        cfg_base = b;
        change = (clamp_log2(l) != m_log2) || (b != m_base);
        @(posedge clk); #1;
        m_log2 = clamp_log2(l);
        m_base = b;
        if (change) begin
            m_idx = 0;
            m_tog = 1'b1;
            check_state("R8/R10 cfg change");
        end else begin
            check_state("R9 cfg same");
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_idx = 0; m_tog = 1'b1; m_log2 = RST_LOG2; m_base = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check_state("R1 reset");
        chk(last_entry == 0 && !mem_req_valid && evt_ready, "R1 reset", last_entry, 0);

        push(31'h10, 0);
        push(31'h7fff_ffff, 2);
        push(31'h0, 1);
        // R8: change size and base restarts the ring; then wrap 4-slot ring twice
        cfg(2, 32'h1000);
        for (int i = 0; i < 9; i++) push(31'(i + 1), i % 3);
        // R9: identical write leaves index/toggle
        cfg(2, 32'h1000);
        push(31'h55, 0);
        // R3: address wrap near the top of the address space
        cfg(2, 32'hFFFF_FFF8);
        for (int i = 0; i < 3; i++) push(31'h100 + 31'(i), 0);
        // R5: one-slot ring flips toggle every write
        cfg(0, 32'h40);
        for (int i = 0; i < 4; i++) push(31'h200 + 31'(i), 1);
        // R10: oversize request clamps
        cfg(31, 32'h40);
        push(31'h300, 0);
        // R8: event alongside a config write is refused
        @(negedge clk);
        cfg_we = 1'b1; cfg_log2 = 5'd3; cfg_base = 32'h80;
        evt_valid = 1'b1; evt_data = 31'h3;
        #0.5;
        chk(evt_ready == 1'b0, "R8 ready during cfg", 32'(evt_ready), 32'd0);
        @(posedge clk); #1;
        chk(mem_req_valid == 1'b0, "R8 no accept", 32'(mem_req_valid), 32'd0);
        m_log2 = 3; m_base = 32'h80; m_idx = 0; m_tog = 1'b1;
        check_state("R8 collide");
        @(negedge clk);
        cfg_we = 1'b0; evt_valid = 1'b0;
        // Random phase
        for (int n = 0; n < 300; n++) begin
            if ($urandom % 20 == 0) cfg(int'($urandom % 6), $urandom & 32'hFFFF_FFF0);
            else push(31'($urandom), int'($urandom % 4));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule